// File: doc/BRIEF.md
# Indirect Jump Target Predictor

This block guesses where an indirect jump will go before the jump has computed its destination. The fetch side presents a program counter together with a jump kind. Returns are answered from a small return-address stack. Every other indirect jump, including an indirect call, is answered from a direct-mapped table that remembers the last destination seen for that jump. The answer is a target address with a valid flag. It is registered, so it appears in the cycle after the lookup.

A call lookup pushes the address of the following instruction onto the stack. A return lookup pops the stack. When an indirect jump resolves, the back end reports its program counter and real destination on the update port. The entry in the table is then overwritten, so the table always holds the most recent destination for each jump.

Top module: `ind_target_pred`

## Requirements
- R1: After reset, `pred_valid` is 0, the stack is empty and every table entry is invalid, so the first lookups of any kind give no prediction.
- R2: The prediction is registered. A lookup presented in one cycle drives `pred_valid`/`pred_target` after the next rising edge. A cycle with `lk_valid` low gives `pred_valid` 0 and leaves the stack unchanged.
- R3: A call lookup (`lk_kind` = 1) pushes `lk_pc + 4` onto the stack. The call's own prediction comes from the table.
- R4: A return lookup (`lk_kind` = 2) on a non-empty stack predicts the top entry and pops it, so nested calls come back in last-in, first-out order.
- R5: A return lookup on an empty stack gives `pred_valid` 0 and leaves the stack empty.
- R6: The stack holds 8 entries. A push onto a full stack overwrites the oldest entry, so after 9 calls the next 8 returns give the 9th down to the 2nd call's return address, and the return after those gives no prediction.
- R7: A jump lookup (`lk_kind` = 3) or call lookup predicts the stored target when the entry selected by `pc[7:2]` is valid and its stored tag equals `pc[17:8]`.
- R8: When the stored tag differs from `pc[17:8]`, the table lookup gives `pred_valid` 0, even if the entry is valid.
- R9: An update with `up_valid` 1 and `up_is_ret` 0 writes the entry for `up_pc` with `up_target` and the tag. A later update to the same jump replaces the earlier target.
- R10: An update with `up_is_ret` 1 leaves the table unchanged.
- R11: When a lookup and an update hit the same entry in the same cycle, the lookup returns the contents from before that update. The next lookup returns the new target.
- R12: `lk_kind` = 0 marks a non-indirect instruction: no prediction and no stack change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup present this cycle |
| lk_pc | input | 32 | Program counter of the looked-up instruction |
| lk_kind | input | 2 | 0 none, 1 call, 2 return, 3 other indirect jump |
| up_valid | input | 1 | Resolved indirect jump reported this cycle |
| up_pc | input | 32 | Program counter of the resolved jump |
| up_is_ret | input | 1 | Resolved jump was a return |
| up_target | input | 32 | Actual destination of the resolved jump |
| pred_valid | output | 1 | Prediction below is usable |
| pred_target | output | 32 | Predicted destination, zero when not valid |

## Verification
The hardest state to reach is a stack that has wrapped. It takes nine calls in a row with no return between them. Then eight returns must drain it before the lost oldest entry can show up as an underflow. The stimulus builds exactly that sequence and checks each popped address in order. It then places a lookup and an update on the same table entry in one cycle. This shows that the old target is seen first and the new one on the following lookup.

// File: rtl/itp_pkg.sv
package itp_pkg;

  localparam int PC_W = 32;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_CALL = 2'd1,
    KIND_RET  = 2'd2,
    KIND_JMP  = 2'd3
  } jkind_e;

  // Address of the instruction after a 4-byte call.
  function automatic logic [PC_W-1:0] next_seq_pc(input logic [PC_W-1:0] pc);
    return pc + PC_W'(4);
  endfunction

endpackage

// File: rtl/itp_ret_stack.sv
module itp_ret_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] push_data,
  output logic [W-1:0] top_data,
  output logic         empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     slots [DEPTH];
  logic [PTR_W-1:0] top_ptr;
  logic [CNT_W-1:0] fill;

  function automatic logic [PTR_W-1:0] ptr_up(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PTR_W-1:0] ptr_down(input logic [PTR_W-1:0] p);
    return (p == '0) ? PTR_W'(DEPTH - 1) : p - 1'b1;
  endfunction

  assign empty    = (fill == '0);
  assign top_data = slots[top_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      top_ptr <= '0;
      fill    <= '0;
    end else if (push) begin
      top_ptr <= ptr_up(top_ptr);
      if (fill != CNT_W'(DEPTH)) fill <= fill + 1'b1;
    end else if (pop && !empty) begin
      top_ptr <= ptr_down(top_ptr);
      fill    <= fill - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) slots[ptr_up(top_ptr)] <= push_data;
  end

endmodule

// File: rtl/itp_target_table.sv
module itp_target_table #(
  parameter int DEPTH = 64,
  parameter int TAG_W = 10,
  parameter int W     = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rd_pc,
  output logic         rd_hit,
  output logic [W-1:0] rd_target,
  input  logic         wr_en,
  input  logic [W-1:0] wr_pc,
  input  logic [W-1:0] wr_target
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int TAG_LO = IDX_W + 2;

  logic [DEPTH-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [W-1:0]     tgt_q [DEPTH];

  function automatic logic [IDX_W-1:0] index_of(input logic [W-1:0] pc);
    return pc[IDX_W+1:2];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [W-1:0] pc);
    return pc[TAG_LO+TAG_W-1:TAG_LO];
  endfunction

  logic [IDX_W-1:0] rd_idx, wr_idx;
  assign rd_idx = index_of(rd_pc);
  assign wr_idx = index_of(wr_pc);

  // Reads see contents before this cycle's write lands.
  assign rd_hit    = valid_q[rd_idx] && (tag_q[rd_idx] == tag_of(rd_pc));
  assign rd_target = tgt_q[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) valid_q <= '0;
    else if (wr_en) valid_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx] <= tag_of(wr_pc);
      tgt_q[wr_idx] <= wr_target;
    end
  end

endmodule

// File: rtl/ind_target_pred.sv
module ind_target_pred
  import itp_pkg::*;
#(
  parameter int TBL_DEPTH = 64,
  parameter int TAG_W     = 10,
  parameter int RAS_DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lk_valid,
  input  logic [PC_W-1:0] lk_pc,
  input  logic [1:0]      lk_kind,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_is_ret,
  input  logic [PC_W-1:0] up_target,
  output logic            pred_valid,
  output logic [PC_W-1:0] pred_target
);
  // Named internal events, observed by the bound checker.
  logic            is_call, is_ret, is_jmp;
  logic            stk_push, stk_pop, stk_underflow;
  logic            ras_empty;
  logic [PC_W-1:0] ras_top;
  logic            tbl_hit, tbl_wr;
  logic [PC_W-1:0] tbl_target;
  logic            pv_d;
  logic [PC_W-1:0] pt_d;

  assign is_call = lk_valid && (lk_kind == KIND_CALL);
  assign is_ret  = lk_valid && (lk_kind == KIND_RET);
  assign is_jmp  = lk_valid && (lk_kind == KIND_JMP);

  assign stk_push      = is_call;
  assign stk_pop       = is_ret && !ras_empty;
  assign stk_underflow = is_ret && ras_empty;
  assign tbl_wr        = up_valid && !up_is_ret;

  itp_ret_stack #(.DEPTH(RAS_DEPTH), .W(PC_W)) u_ras (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (stk_push),
    .pop       (stk_pop),
    .push_data (next_seq_pc(lk_pc)),
    .top_data  (ras_top),
    .empty     (ras_empty)
  );

  itp_target_table #(.DEPTH(TBL_DEPTH), .TAG_W(TAG_W), .W(PC_W)) u_tbl (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_pc     (lk_pc),
    .rd_hit    (tbl_hit),
    .rd_target (tbl_target),
    .wr_en     (tbl_wr),
    .wr_pc     (up_pc),
    .wr_target (up_target)
  );

  always_comb begin
    pv_d = 1'b0;
    pt_d = '0;
    if (is_ret) begin
      pv_d = !ras_empty;
      pt_d = ras_empty ? '0 : ras_top;
    end else if (is_call || is_jmp) begin
      pv_d = tbl_hit;
      pt_d = tbl_hit ? tbl_target : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pred_valid  <= 1'b0;
      pred_target <= '0;
    end else begin
      pred_valid  <= pv_d;
      pred_target <= pt_d;
    end
  end

endmodule

// File: rtl/itp_chk.sv
module itp_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        lk_valid,
  input logic [1:0]  lk_kind,
  input logic        pred_valid,
  input logic [31:0] pred_target,
  input logic        stk_push,
  input logic        stk_pop,
  input logic        stk_underflow,
  input logic        ras_empty,
  input logic [31:0] ras_top,
  input logic        tbl_wr,
  input logic        up_valid,
  input logic        up_is_ret
);
  // R2
  idle_no_pred_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !pred_valid);

  // R12
  none_kind_no_pred_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_kind == 2'd0) |=> !pred_valid);

  // R3
  call_fills_stack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stk_push |=> !ras_empty);

  // R4
  ret_gives_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stk_pop |=> (pred_valid && pred_target == $past(ras_top)));

  // R5
  underflow_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stk_underflow |=> (!pred_valid && ras_empty));

  // R10
  ret_update_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_is_ret) |-> !tbl_wr);

  // R4
  push_pop_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(stk_push && stk_pop));
endmodule

bind ind_target_pred itp_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .lk_valid      (lk_valid),
  .lk_kind       (lk_kind),
  .pred_valid    (pred_valid),
  .pred_target   (pred_target),
  .stk_push      (stk_push),
  .stk_pop       (stk_pop),
  .stk_underflow (stk_underflow),
  .ras_empty     (ras_empty),
  .ras_top       (ras_top),
  .tbl_wr        (tbl_wr),
  .up_valid      (up_valid),
  .up_is_ret     (up_is_ret)
);

// File: tb/ind_target_pred_bench.sv
module ind_target_pred_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_pc = '0;
  logic [1:0]  lk_kind = 2'd0;
  logic        up_valid = 1'b0;
  logic [31:0] up_pc = '0;
  logic        up_is_ret = 1'b0;
  logic [31:0] up_target = '0;
  logic        pred_valid;
  logic [31:0] pred_target;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Scoreboard queues: one item per driven cycle.
  bit          q_v [$];
  logic [31:0] q_t [$];
  string       q_r [$];

  localparam logic [1:0] K_NONE = 2'd0, K_CALL = 2'd1, K_RET = 2'd2, K_JMP = 2'd3;

  always #10 clk = ~clk;

  ind_target_pred u_ind_target_pred (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_pc(lk_pc),
    .lk_kind(lk_kind), .up_valid(up_valid), .up_pc(up_pc),
    .up_is_ret(up_is_ret), .up_target(up_target),
    .pred_valid(pred_valid), .pred_target(pred_target)
  );

  // Monitor: after each edge, compare the result of the lookup just captured.
  always begin
    @(posedge clk);
    #2;
    if (q_v.size() != 0) begin
      bit          ev;
      logic [31:0] et;
      string       rq;
      ev = q_v.pop_front();
      et = q_t.pop_front();
      rq = q_r.pop_front();
      checks++;
      if (pred_valid !== ev || (ev && pred_target !== et)) begin
        errors++;
        $display("FAIL %s: got valid=%0b target=%h, expected valid=%0b target=%h",
                 rq, pred_valid, pred_target, ev, et);
      end
    end
  end

  // Driver: one cycle of stimulus plus the expected result.
  task automatic drive(input logic lv, input logic [31:0] lpc, input logic [1:0] lk,
                       input logic uv, input logic [31:0] upc, input logic ur,
                       input logic [31:0] ut, input bit ev, input logic [31:0] et,
                       input string rq);
    @(negedge clk);
    lk_valid = lv; lk_pc = lpc; lk_kind = lk;
    up_valid = uv; up_pc = upc; up_is_ret = ur; up_target = ut;
    q_v.push_back(ev); q_t.push_back(et); q_r.push_back(rq);
  endtask

  task automatic look(input logic [31:0] pc, input logic [1:0] k,
                      input bit ev, input logic [31:0] et, input string rq);
    drive(1'b1, pc, k, 1'b0, '0, 1'b0, '0, ev, et, rq);
  endtask

  task automatic upd(input logic [31:0] pc, input logic ret, input logic [31:0] t,
                     input string rq);
    drive(1'b0, '0, K_NONE, 1'b1, pc, ret, t, 1'b0, '0, rq);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got hung run, expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    checks++; // R1 reset output
    if (pred_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1: got valid=%0b, expected valid=0", pred_valid);
    end

    // R1: empty table and stack
    look(32'h1000, K_JMP, 0, '0, "R1 table empty");
    look(32'h1000, K_RET, 0, '0, "R1 stack empty");

    // R7 / R9: learn a target, then hit (idx pc[7:2]=0, tag pc[17:8]=0x10)
    upd(32'h1000, 1'b0, 32'h2000, "R9 update idle");
    look(32'h1000, K_JMP, 1, 32'h2000, "R7 table hit");
    // R8: same index, tag 0x11
    look(32'h1100, K_JMP, 0, '0, "R8 tag mismatch");
    // R11: same-cycle lookup and update of the same entry
    drive(1'b1, 32'h1000, K_JMP, 1'b1, 32'h1000, 1'b0, 32'h3000, 1, 32'h2000, "R11 old value");
    look(32'h1000, K_JMP, 1, 32'h3000, "R9 R11 new value");
    // R10: return update does not write
    upd(32'h1100, 1'b1, 32'h5555, "R10 ret update idle");
    look(32'h1100, K_JMP, 0, '0, "R10 no table write");
    // R12 / R2
    look(32'h1000, K_NONE, 0, '0, "R12 kind none");
    drive(1'b0, 32'h1000, K_JMP, 1'b0, '0, 1'b0, '0, 0, '0, "R2 lookup invalid");

    // R3 / R4: call then return
    look(32'h400, K_CALL, 0, '0, "R3 call miss");
    look(32'h400, K_RET, 1, 32'h404, "R3 return address");
    // R4 nesting
    look(32'h100, K_CALL, 0, '0, "R4 call a");
    look(32'h200, K_CALL, 0, '0, "R4 call b");
    look(32'h300, K_CALL, 0, '0, "R4 call c");
    look(32'h0, K_RET, 1, 32'h304, "R4 pop c");
    look(32'h0, K_RET, 1, 32'h204, "R4 pop b");
    look(32'h0, K_RET, 1, 32'h104, "R4 pop a");
    // R5 underflow, then stack still usable
    look(32'h0, K_RET, 0, '0, "R5 underflow");
    look(32'h600, K_CALL, 0, '0, "R5 call after");
    look(32'h0, K_RET, 1, 32'h604, "R5 pop after");

    // R6: nine calls into an 8-entry stack
    for (int k = 1; k <= 9; k++)
      look(32'(k * 32'h40), K_CALL, 0, '0, "R6 fill");
    for (int k = 9; k >= 2; k--)
      look(32'h0, K_RET, 1, 32'(k * 32'h40 + 32'h4), "R6 drain");
    look(32'h0, K_RET, 0, '0, "R6 oldest lost");

    // R3 / R7: indirect call predicted from the table
    upd(32'h2040, 1'b0, 32'h9000, "R7 update call");
    look(32'h2040, K_CALL, 1, 32'h9000, "R3 call hit");
    look(32'h0, K_RET, 1, 32'h2044, "R3 call return");

    // R2: a return with lk_valid low does not pop
    look(32'h700, K_CALL, 0, '0, "R2 call");
    drive(1'b0, 32'h0, K_RET, 1'b0, '0, 1'b0, '0, 0, '0, "R2 idle return");
    look(32'h0, K_RET, 1, 32'h704, "R2 stack kept");
    look(32'h0, K_RET, 0, '0, "R2 empty again");

    @(negedge clk);
    lk_valid = 1'b0; up_valid = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule